// File: doc/BRIEF.md
# Serial/Parallel FIFO Entry Register

This block is the front stage of a 4-bit first-in first-out buffer. It collects one data word, either in a single parallel load or as a train of serial bits. When the word is complete it drops a full flag. When a transfer request arrives and the storage stack can accept a word, it hands the word on. The stack itself sits downstream: it takes a one-cycle write strobe with the word and reports back whether its top slot is free.

Completion of a serial word is found without a bit counter. On re-arm, a single marker bit is preloaded at the entry end of a chain one stage longer than the word. Each serial shift moves the marker one place. When it reaches the far stage, the word is complete and further shifts are locked out. After a transfer, a one-shot latch stops the same word from being written twice. Re-arming waits until the parallel-load strobe is released. A slice can be strapped as a master or as a slave, so that several slices side by side form a wider word. A master re-arms at once after its transfer. A slave waits for a low level from its neighbour on its serial-enable pin.

Everything runs on one system clock. The serial clock is synchronized, and its falling edges are detected inside the block. The control strobes are sampled levels.

Top module: `sp_fifo_inreg`

## Requirements
- R1: While `rst` is high at a clock edge, the register re-arms. After that edge `in_full_n` is 1 and `stk_wr` is 0, and the slice takes the slave role until a role strobe is applied.
- R2: A clock edge that samples `pl` high loads `par_d` into the word and sets the marker, so `in_full_n` reads 0 after that edge. Bit i of `par_d` becomes bit i of the word.
- R3: Each falling edge of `ser_clk` seen while `ser_en_n` is low shifts `ser_d` into the word. The bit that arrives first ends up in bit 0 of the word. `in_full_n` stays 1 after three shifts and reads 0 no later than three clock edges after the fourth falling edge.
- R4: Falling edges of `ser_clk` while `ser_en_n` is high shift nothing, and `in_full_n` stays 1.
- R5: Once the word is full, further serial edges change neither the word nor the full flag until the register re-arms.
- R6: When the word is full, `tts_n` is low, `stk_top_empty` is high and no transfer is pending, `stk_wr` is 1 for exactly one cycle after the next edge, and `stk_data` carries the word.
- R7: While `stk_top_empty` is low, no write happens and the word stays full. The write happens once the top slot frees up.
- R8: A word is written at most once, even while `tts_n` stays low and the register is still full.
- R9: After a transfer, the register does not re-arm while `pl` is high, so `in_full_n` stays 0.
- R10: A master re-arms on the first edge after its transfer at which `pl` is low. `in_full_n` then reads 1.
- R11: A slave with a pending transfer stays full while `ser_en_n` is high. It re-arms on the first edge at which `ser_en_n` is low.
- R12: An edge that samples `mr_n` low re-arms the register without a write. It also fixes the role: master if `ser_en_n` is low, slave if it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pl | input | 1 | Parallel load strobe, active high |
| par_d | input | DATA_W | Parallel data word |
| ser_clk | input | 1 | Serial clock; data shifts on its falling edge |
| ser_en_n | input | 1 | Serial enable, active low; also the role and re-arm link from the neighbour |
| ser_d | input | 1 | Serial data bit |
| tts_n | input | 1 | Transfer request to the stack, active low |
| mr_n | input | 1 | Control re-arm and role strobe, active low |
| stk_top_empty | input | 1 | High when the stack's top slot can take a word |
| in_full_n | output | 1 | Low when a full word is held |
| stk_wr | output | 1 | One-cycle stack write strobe |
| stk_data | output | DATA_W | Word written to the stack |

## Verification
The bench drives a request that stays low while `pl` is held high. A design without the one-shot latch would write the same word on every cycle, and one that re-armed too early would lose the word before the stack took it. It feeds a fifth serial bit into a full register: a missing shift lockout would push the marker out and corrupt the word. It sends serial bits with the enable high, and it blocks the transfer with a busy stack: a wrong gate would show up as a spurious fill or a write into an occupied slot. It also holds a slave's neighbour link high after its transfer. A slave that re-armed like a master would raise its flag too early and break the lockstep of a wide array.

// File: rtl/sp_fifo_pkg.sv
package sp_fifo_pkg;
  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;
endpackage

// File: rtl/sp_fifo_edge_det.sv
// Synchronizes an asynchronous level and flags its falling edges.
module sp_fifo_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/sp_fifo_chain.sv
// Word register plus completion marker. Stage 0 is the marker; stage
// i+1 holds word bit i; serial data enters at the top stage.
module sp_fifo_chain #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rearm,
  input  logic              load,
  input  logic [DATA_W-1:0] par_d,
  input  logic              shift,
  input  logic              ser_d,
  output logic [DATA_W-1:0] word,
  output logic              mark
);
  localparam int CHAIN_W = DATA_W + 1;
  localparam logic [CHAIN_W-1:0] ARMED = CHAIN_W'(1) << DATA_W;

  logic [CHAIN_W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst || rearm) begin
      st_q <= ARMED;
    end else if (load) begin
      st_q <= {par_d, 1'b1};
    end else if (shift) begin
      st_q <= {ser_d, st_q[CHAIN_W-1:1]};
    end
  end

  assign word = st_q[CHAIN_W-1:1];
  assign mark = st_q[0];
endmodule

// File: rtl/sp_fifo_xfer_ctrl.sv
// Transfer one-shot, role latch and re-arm interlock.
module sp_fifo_xfer_ctrl
  import sp_fifo_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  full,
  input  logic  tts_n,
  input  logic  top_empty,
  input  logic  pl,
  input  logic  ser_en_n,
  input  logic  mr_n,
  output logic  wr_go,
  output logic  rearm,
  output logic  done_q,
  output role_e role_q
);
  logic release_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      role_q <= ROLE_SLAVE;
    end else if (!mr_n) begin
      role_q <= ser_en_n ? ROLE_SLAVE : ROLE_MASTER;
    end
  end

  assign wr_go      = full & ~tts_n & top_empty & ~done_q & mr_n;
  assign release_ok = done_q & ~pl & ((role_q == ROLE_MASTER) | ~ser_en_n);
  assign rearm      = ~mr_n | release_ok;

  always_ff @(posedge clk) begin
    if (rst || !mr_n) begin
      done_q <= 1'b0;
    end else if (wr_go) begin
      done_q <= 1'b1;
    end else if (release_ok) begin
      done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sp_fifo_inreg.sv
module sp_fifo_inreg
  import sp_fifo_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pl,
  input  logic [DATA_W-1:0] par_d,
  input  logic              ser_clk,
  input  logic              ser_en_n,
  input  logic              ser_d,
  input  logic              tts_n,
  input  logic              mr_n,
  input  logic              stk_top_empty,
  output logic              in_full_n,
  output logic              stk_wr,
  output logic [DATA_W-1:0] stk_data
);
  logic              ser_fall;
  logic              shift;
  logic              mark;
  logic [DATA_W-1:0] word;
  logic              wr_go;
  logic              rearm;
  logic              done_q;
  role_e             role_q;
  logic              is_master;

  sp_fifo_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .async_in (ser_clk),
    .fall     (ser_fall)
  );

  assign shift = ser_fall & ~ser_en_n & ~mark & ~pl;

  sp_fifo_chain #(.DATA_W(DATA_W)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .rearm (rearm),
    .load  (pl),
    .par_d (par_d),
    .shift (shift),
    .ser_d (ser_d),
    .word  (word),
    .mark  (mark)
  );

  sp_fifo_xfer_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .full      (mark),
    .tts_n     (tts_n),
    .top_empty (stk_top_empty),
    .pl        (pl),
    .ser_en_n  (ser_en_n),
    .mr_n      (mr_n),
    .wr_go     (wr_go),
    .rearm     (rearm),
    .done_q    (done_q),
    .role_q    (role_q)
  );

  assign is_master = (role_q == ROLE_MASTER);

  always_ff @(posedge clk) begin
    if (rst) begin
      stk_wr   <= 1'b0;
      stk_data <= '0;
    end else begin
      stk_wr <= wr_go;
      if (wr_go) begin
        stk_data <= word;
      end
    end
  end

  assign in_full_n = ~mark;
endmodule

// File: rtl/sp_fifo_inreg_chk.sv
module sp_fifo_inreg_chk (
  input logic clk,
  input logic rst,
  input logic pl,
  input logic mr_n,
  input logic tts_n,
  input logic ser_en_n,
  input logic stk_top_empty,
  input logic in_full_n,
  input logic stk_wr,
  input logic done_q,
  input logic is_master
);
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stk_wr |=> !stk_wr); // R8
  AST_WR_GUARD: assert property (@(posedge clk) disable iff (rst)
    stk_wr |-> $past(!in_full_n && !tts_n && stk_top_empty)); // R6
  AST_PL_FILLS: assert property (@(posedge clk) disable iff (rst)
    (pl && mr_n) |=> !in_full_n); // R2
  AST_MR_REARM: assert property (@(posedge clk) disable iff (rst)
    !mr_n |=> in_full_n); // R12
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!in_full_n && !done_q && mr_n) |=> !in_full_n); // R5
  AST_PL_DEFERS: assert property (@(posedge clk) disable iff (rst)
    (done_q && pl && mr_n) |=> !in_full_n); // R9
  AST_MASTER_REARM: assert property (@(posedge clk) disable iff (rst)
    (done_q && is_master && !pl && mr_n) |=> in_full_n); // R10
  AST_SLAVE_WAITS: assert property (@(posedge clk) disable iff (rst)
    (done_q && !is_master && ser_en_n && mr_n) |=> !in_full_n); // R11
endmodule

bind sp_fifo_inreg sp_fifo_inreg_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .pl            (pl),
  .mr_n          (mr_n),
  .tts_n         (tts_n),
  .ser_en_n      (ser_en_n),
  .stk_top_empty (stk_top_empty),
  .in_full_n     (in_full_n),
  .stk_wr        (stk_wr),
  .done_q        (done_q),
  .is_master     (is_master)
);

// File: tb/sp_fifo_inreg_tb.sv
module sp_fifo_inreg_tb;
  logic       clk = 1'b0;
  logic       rst, pl, ser_clk, ser_en_n, ser_d, tts_n, mr_n, stk_top_empty;
  logic [3:0] par_d;
  logic       in_full_n, stk_wr;
  logic [3:0] stk_data;

  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  logic [3:0] last_data = 4'h0;

  always #4 clk = ~clk;

  sp_fifo_inreg u_dut (
    .clk(clk), .rst(rst), .pl(pl), .par_d(par_d), .ser_clk(ser_clk),
    .ser_en_n(ser_en_n), .ser_d(ser_d), .tts_n(tts_n), .mr_n(mr_n),
    .stk_top_empty(stk_top_empty), .in_full_n(in_full_n),
    .stk_wr(stk_wr), .stk_data(stk_data)
  );

  always @(posedge clk) begin
    if (!rst && stk_wr) begin
      wr_cnt    <= wr_cnt + 1;
      last_data <= stk_data;
    end
  end

  localparam int NVEC = 6;
  localparam logic [3:0] VEC [NVEC] = '{4'h0, 4'hF, 4'hA, 4'h5, 4'h3, 4'hC};

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_d   = b;
    ser_clk = 1'b1;
    step(4);
    ser_clk = 1'b0;
    step(4);
  endtask

  task automatic pload(input logic [3:0] v);
    par_d = v;
    pl    = 1'b1;
    step(1);
    pl    = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base;
    rst = 1'b1; pl = 1'b0; par_d = 4'h0; ser_clk = 1'b0; ser_en_n = 1'b0;
    ser_d = 1'b0; tts_n = 1'b1; mr_n = 1'b1; stk_top_empty = 1'b1;
    step(3);
    chk("R1 flag", int'(in_full_n), 1);
    chk("R1 strobe", int'(stk_wr), 0);
    rst = 1'b0;
    step(1);

    // Role strobe with enable low: master (R12)
    mr_n = 1'b0;
    step(1);
    chk("R12 rearm", int'(in_full_n), 1);
    mr_n = 1'b1;
    step(1);

    // Vector table: parallel load then transfer (R2, R6, R10)
    for (int i = 0; i < NVEC; i++) begin
      base = wr_cnt;
      pload(VEC[i]);
      chk("R2 full", int'(in_full_n), 0);
      tts_n = 1'b0;
      step(2);
      chk("R6 count", wr_cnt, base + 1);
      chk("R6 data", int'(last_data), int'(VEC[i]));
      chk("R10 rearm", int'(in_full_n), 1);
      tts_n = 1'b1;
      step(1);
    end

    // R8 / R9: request held low while pl held high
    base = wr_cnt;
    par_d = 4'h7; pl = 1'b1; tts_n = 1'b0;
    step(6);
    chk("R8 once", wr_cnt, base + 1);
    chk("R8 data", int'(last_data), 7);
    chk("R9 held", int'(in_full_n), 0);
    pl = 1'b0;
    step(1);
    chk("R10 after pl", int'(in_full_n), 1);
    step(3);
    chk("R8 no repeat", wr_cnt, base + 1);
    tts_n = 1'b1;
    step(1);

    // R7: stack busy
    base = wr_cnt;
    stk_top_empty = 1'b0;
    pload(4'h5);
    tts_n = 1'b0;
    step(5);
    chk("R7 blocked", wr_cnt, base);
    chk("R7 still full", int'(in_full_n), 0);
    stk_top_empty = 1'b1;
    step(2);
    chk("R7 released", wr_cnt, base + 1);
    chk("R7 data", int'(last_data), 5);
    tts_n = 1'b1;
    step(1);

    // R4: serial edges with enable high
    ser_en_n = 1'b1;
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    chk("R4 ignored", int'(in_full_n), 1);
    ser_en_n = 1'b0;
    step(1);

    // R3: serial word 1,0,1,1 (first bit -> bit 0)
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    chk("R3 three bits", int'(in_full_n), 1);
    send_bit(1'b1);
    chk("R3 full", int'(in_full_n), 0);
    // R5: extra edges once full
    send_bit(1'b0);
    send_bit(1'b0);
    chk("R5 still full", int'(in_full_n), 0);
    base = wr_cnt;
    tts_n = 1'b0;
    step(2);
    chk("R3 count", wr_cnt, base + 1);
    chk("R5 word", int'(last_data), 4'hD);
    tts_n = 1'b1;
    step(1);

    // R11: slave waits for neighbour
    ser_en_n = 1'b1;
    mr_n = 1'b0;
    step(1);
    mr_n = 1'b1;
    step(1);
    base = wr_cnt;
    pload(4'h9);
    tts_n = 1'b0;
    step(2);
    chk("R11 write", wr_cnt, base + 1);
    chk("R11 data", int'(last_data), 9);
    step(4);
    chk("R11 waits", int'(in_full_n), 0);
    ser_en_n = 1'b0;
    step(1);
    chk("R11 rearm", int'(in_full_n), 1);
    tts_n = 1'b1;
    step(1);

    // R12: re-arm strobe on a full register, no write
    base = wr_cnt;
    pload(4'h6);
    chk("R12 full first", int'(in_full_n), 0);
    mr_n = 1'b0;
    step(1);
    chk("R12 cleared", int'(in_full_n), 1);
    mr_n = 1'b1;
    step(3);
    chk("R12 no write", wr_cnt, base);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule